// File: doc/BRIEF.md
# Triangle-Carrier PWM with Slope-Reversal Sample Strobe

This block drives the gate of a single boost switch from an up/down (triangle) carrier. Internally the carrier sweeps from its top value down to zero and back up. The gate is high while the active compare word is above the carrier, so each on-pulse is centred on the carrier valley and each off-interval is centred on the carrier top. A one-cycle sample strobe for the current-sense converter is issued once per switching period. It falls at the valley, the middle of the on-pulse, when the compare word is above half scale. Otherwise it falls at the top, the middle of the off-interval. The strobe therefore never lands next to a gate edge, and in continuous conduction each sample equals the average inductor current.

The controller supplies a duty word and a signed trim offset. The offset cancels a fixed duty error introduced by the drive path. The trimmed word is captured once, on the clock edge that opens a switching period. It then stays fixed for the whole period, so the peak and valley of that period always use the same value. A period-start flag marks the first cycle of each period. The next duty word must be presented before the edge that ends that period. All pins are plain level signals: nothing flows in a stream, and there is no handshake or back-pressure.

Top module: `pwm_center_trig`

## Requirements
- R1: With MAX = 2^CNT_W−1, `prd_start_o` is high for exactly one cycle every 2·MAX cycles. Index the cycles of a period j = 0 … 2·MAX−1, with j = 0 the flagged cycle. The carrier value in cycle j is |MAX−j|.
- R2: The effective compare word is E. For 0 < E < MAX, `gate_o` is high in cycle j exactly when E > |MAX−j|. This gives one contiguous pulse of 2·E−1 cycles centred on j = MAX.
- R3: E is taken from `duty_i` and `ofs_i` as sampled at the clock edge that begins cycle j = 0. Changes to either input later in the period have no effect on that period's gate or strobe.
- R4: Every period carries exactly one strobe on `smp_o`, one cycle wide. It is at j = MAX (valley) when E > 2^(CNT_W−1), and at j = 0 (top) otherwise.
- R5: E = clamp(duty_i + ofs_i, 0, MAX). `duty_i` is unsigned and `ofs_i` is two's complement.
- R6: With E = 0 the gate stays low through the whole period. With E = MAX it stays high through all 2·MAX cycles. In both cases the strobe keeps its once-per-period timing.
- R7: `en_i` is registered. In a cycle whose preceding edge sampled `en_i` low, the outputs `gate_o`, `smp_o` and `prd_start_o` are all low. The first cycle after an edge that samples `en_i` high again is j = 0 of a new period.
- R8: While `rst_n` is low, all outputs are low. After release the block behaves as if `en_i` had been low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| en_i | input | 1 | Run enable, registered inside |
| duty_i | input | CNT_W | Unsigned duty word |
| ofs_i | input | OFS_W | Signed duty trim offset |
| gate_o | output | 1 | Switch gate drive |
| smp_o | output | 1 | One-cycle current sample strobe |
| prd_start_o | output | 1 | First cycle of a switching period |

## Verification
A carrier that skips or repeats a step shows at the ports within one period. Either the flag spacing departs from 2·MAX cycles, or the pulse width departs from 2·E−1 cycles. A compare word captured on the wrong edge shows as an off-centre pulse, or as a strobe in the wrong half, in the first period after the duty changes. A wrong half-scale decision moves the strobe by MAX cycles only for words next to half scale, so the sweep covers every duty word, including both sides of that boundary.

// File: rtl/pwm_ctr_pkg.sv
`timescale 1ns/1ps
package pwm_ctr_pkg;
  typedef enum logic {
    SLOPE_DOWN = 1'b0,
    SLOPE_UP   = 1'b1
  } slope_e;
endpackage

// File: rtl/pwm_ctr_carrier.sv
`timescale 1ns/1ps
module pwm_ctr_carrier
  import pwm_ctr_pkg::*;
#(
  parameter int CNT_W = 10
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             run_i,
  output logic [CNT_W-1:0] cnt_o,
  output logic             peak_o,
  output logic             valley_o,
  output logic             reload_o
);
  localparam logic [CNT_W-1:0] TOP    = {CNT_W{1'b1}};
  localparam logic [CNT_W-1:0] TOP_M1 = {{(CNT_W-1){1'b1}}, 1'b0};

  logic [CNT_W-1:0] cnt_q;
  slope_e           slope_q;

  // Idle parks the carrier at the top so a restart opens a fresh period.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q   <= TOP;
      slope_q <= SLOPE_DOWN;
    end else if (!run_i) begin
      cnt_q   <= TOP;
      slope_q <= SLOPE_DOWN;
    end else if (cnt_q == '0) begin
      cnt_q   <= cnt_q + 1'b1;
      slope_q <= SLOPE_UP;
    end else if (cnt_q == TOP) begin
      cnt_q   <= cnt_q - 1'b1;
      slope_q <= SLOPE_DOWN;
    end else if (slope_q == SLOPE_UP) begin
      cnt_q <= cnt_q + 1'b1;
    end else begin
      cnt_q <= cnt_q - 1'b1;
    end
  end

  assign cnt_o    = cnt_q;
  assign peak_o   = (cnt_q == TOP);
  assign valley_o = (cnt_q == '0);
  // Capture window: the edge leaving the last rising step enters the top.
  assign reload_o = !run_i || ((slope_q == SLOPE_UP) && (cnt_q == TOP_M1));

  AST_CARRIER_STEP: assert property (@(posedge clk) disable iff (!rst_n)
    run_i |=> ((cnt_q == $past(cnt_q) + 1'b1) || (cnt_q == $past(cnt_q) - 1'b1))); // R1
  AST_TOP_TURNS: assert property (@(posedge clk) disable iff (!rst_n)
    (run_i && (cnt_q == TOP)) |=> (cnt_q == TOP_M1)); // R1
endmodule

// File: rtl/pwm_ctr_trim.sv
`timescale 1ns/1ps
module pwm_ctr_trim #(
  parameter int CNT_W = 10,
  parameter int OFS_W = 7
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    load_i,
  input  logic [CNT_W-1:0]        duty_i,
  input  logic signed [OFS_W-1:0] ofs_i,
  output logic [CNT_W-1:0]        cmp_o
);
  localparam int               SW  = CNT_W + 2;
  localparam logic [CNT_W-1:0] TOP = {CNT_W{1'b1}};

  logic signed [SW-1:0] duty_s;
  logic signed [SW-1:0] ofs_s;
  logic signed [SW-1:0] sum_s;
  logic [CNT_W-1:0]     trim_w;
  logic [CNT_W-1:0]     cmp_q;

  assign duty_s = $signed({2'b00, duty_i});
  assign ofs_s  = $signed({{(SW-OFS_W){ofs_i[OFS_W-1]}}, ofs_i});
  assign sum_s  = duty_s + ofs_s;

  always_comb begin
    if (sum_s < $signed({SW{1'b0}})) begin
      trim_w = '0;
    end else if (sum_s > $signed({2'b00, TOP})) begin
      trim_w = TOP;
    end else begin
      trim_w = sum_s[CNT_W-1:0];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cmp_q <= '0;
    end else if (load_i) begin
      cmp_q <= trim_w;
    end
  end

  assign cmp_o = cmp_q;

  AST_TRIM_NO_NEG_WRAP: assert property (@(posedge clk) disable iff (!rst_n)
    (load_i && (sum_s < $signed({SW{1'b0}}))) |=> (cmp_q == '0)); // R5
endmodule

// File: rtl/pwm_ctr_cmp.sv
`timescale 1ns/1ps
module pwm_ctr_cmp #(
  parameter int CNT_W = 10
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             run_i,
  input  logic [CNT_W-1:0] cnt_i,
  input  logic [CNT_W-1:0] cmp_i,
  input  logic             peak_i,
  input  logic             valley_i,
  output logic             gate_o,
  output logic             smp_o
);
  localparam logic [CNT_W-1:0] TOP  = {CNT_W{1'b1}};
  localparam logic [CNT_W-1:0] HALF = {1'b1, {(CNT_W-1){1'b0}}};

  logic full_w;
  logic on_mid_w;

  assign full_w   = (cmp_i == TOP);
  assign on_mid_w = (cmp_i > HALF);
  assign gate_o   = run_i && (full_w || (cmp_i > cnt_i));
  // Sample inside the wider interval: on-pulse middle or off-interval middle.
  assign smp_o    = run_i && (on_mid_w ? valley_i : peak_i);

  AST_SMP_AT_TURN: assert property (@(posedge clk) disable iff (!rst_n)
    smp_o |-> ((cnt_i == '0) || (cnt_i == TOP))); // R4
  AST_SMP_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
    smp_o |=> !smp_o); // R4
  AST_ZERO_HOLDS_LOW: assert property (@(posedge clk) disable iff (!rst_n)
    (cmp_i == '0) |-> !gate_o); // R6
  AST_FULL_HOLDS_HIGH: assert property (@(posedge clk) disable iff (!rst_n)
    (run_i && full_w) |-> gate_o); // R6
endmodule

// File: rtl/pwm_center_trig.sv
`timescale 1ns/1ps
module pwm_center_trig #(
  parameter int CNT_W = 10,
  parameter int OFS_W = 7
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    en_i,
  input  logic [CNT_W-1:0]        duty_i,
  input  logic signed [OFS_W-1:0] ofs_i,
  output logic                    gate_o,
  output logic                    smp_o,
  output logic                    prd_start_o
);
  logic             en_q;
  logic [CNT_W-1:0] cnt_w;
  logic [CNT_W-1:0] cmp_w;
  logic             peak_w;
  logic             valley_w;
  logic             reload_w;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      en_q <= 1'b0;
    end else begin
      en_q <= en_i;
    end
  end

  pwm_ctr_carrier #(.CNT_W(CNT_W)) carrier_i (
    .clk      (clk),
    .rst_n    (rst_n),
    .run_i    (en_q),
    .cnt_o    (cnt_w),
    .peak_o   (peak_w),
    .valley_o (valley_w),
    .reload_o (reload_w)
  );

  pwm_ctr_trim #(.CNT_W(CNT_W), .OFS_W(OFS_W)) trim_i (
    .clk    (clk),
    .rst_n  (rst_n),
    .load_i (reload_w),
    .duty_i (duty_i),
    .ofs_i  (ofs_i),
    .cmp_o  (cmp_w)
  );

  pwm_ctr_cmp #(.CNT_W(CNT_W)) cmp_i (
    .clk      (clk),
    .rst_n    (rst_n),
    .run_i    (en_q),
    .cnt_i    (cnt_w),
    .cmp_i    (cmp_w),
    .peak_i   (peak_w),
    .valley_i (valley_w),
    .gate_o   (gate_o),
    .smp_o    (smp_o)
  );

  assign prd_start_o = en_q && peak_w;

  AST_CMP_FIXED_IN_PERIOD: assert property (@(posedge clk) disable iff (!rst_n)
    (en_q && !prd_start_o) |-> $stable(cmp_w)); // R3
  AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    !en_q |-> (!gate_o && !smp_o && !prd_start_o)); // R7
  AST_FLAG_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
    prd_start_o |=> !prd_start_o); // R1
endmodule

// File: tb/pwm_center_trig_tb.sv
`timescale 1ns/1ps
module pwm_center_trig_tb_top;
  localparam int CW   = 6;
  localparam int OW   = 4;
  localparam int MAXV = (1 << CW) - 1;
  localparam int P    = 2 * MAXV;
  localparam int HALF = 1 << (CW - 1);

  logic                 clk = 1'b0;
  logic                 rst_n = 1'b0;
  logic                 en = 1'b0;
  logic [CW-1:0]        duty = '0;
  logic signed [OW-1:0] ofs = '0;
  logic                 gate, smp, prd;

  int    checks = 0;
  int    fails = 0;
  bit    was_en = 1'b0;
  bit    full_prd = 1'b0;
  int    j = 0;
  int    e_cur = 0;
  int    hi_cnt = 0;
  int    smp_cnt = 0;
  string gtag = "R2";
  logic [15:0] lf = 16'hACE1;

  always #2.5 clk = ~clk;

  pwm_center_trig #(.CNT_W(CW), .OFS_W(OW)) dut_i (
    .clk         (clk),
    .rst_n       (rst_n),
    .en_i        (en),
    .duty_i      (duty),
    .ofs_i       (ofs),
    .gate_o      (gate),
    .smp_o       (smp),
    .prd_start_o (prd)
  );

  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s act=%0d exp=%0d (j=%0d E=%0d)", req, act, exp, j, e_cur);
    end
  endtask

  function automatic int eff_now();
    int s;
    s = int'(duty) + int'(ofs);
    if (s < 0) s = 0;
    if (s > MAXV) s = MAXV;
    return s;
  endfunction

  // Sample at the falling edge; callers drive inputs after this returns.
  task automatic cyc();
    int cv, eg, es, ew;
    string tg;
    @(negedge clk);
    if (!rst_n) begin
      chk("R8 gate", int'(gate), 0);
      chk("R8 smp", int'(smp), 0);
      chk("R8 prd", int'(prd), 0);
      was_en = 1'b0;
      full_prd = 1'b0;
    end else if (!en) begin
      chk("R7 gate", int'(gate), 0);
      chk("R7 smp", int'(smp), 0);
      chk("R7 prd", int'(prd), 0);
      was_en = 1'b0;
      full_prd = 1'b0;
    end else begin
      j = was_en ? (j + 1) % P : 0;
      if (j == 0) begin
        if (was_en && full_prd) begin
          ew = (e_cur == MAXV) ? P : (e_cur == 0) ? 0 : 2 * e_cur - 1;
          chk((e_cur == 0 || e_cur == MAXV) ? "R6 width" : "R2 width", hi_cnt, ew);
          chk("R4 strobe count", smp_cnt, 1);
        end
        e_cur = eff_now();
        hi_cnt = 0;
        smp_cnt = 0;
        full_prd = 1'b1;
      end
      cv = (MAXV > j) ? MAXV - j : j - MAXV;
      eg = ((e_cur == MAXV) || (e_cur > cv)) ? 1 : 0;
      es = (e_cur > HALF) ? ((j == MAXV) ? 1 : 0) : ((j == 0) ? 1 : 0);
      tg = (e_cur == 0 || e_cur == MAXV) ? "R6 gate" : gtag;
      chk("R1 prd", int'(prd), (j == 0) ? 1 : 0);
      chk(tg, int'(gate), eg);
      chk("R4 smp", int'(smp), es);
      hi_cnt += int'(gate);
      smp_cnt += int'(smp);
      was_en = 1'b1;
    end
  endtask

  task automatic lf_step();
    lf = {lf[14:0], lf[15] ^ lf[13] ^ lf[12] ^ lf[10]};
  endtask

  task automatic finish_run();
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    fails++;
    $display("FAIL watchdog expired");
    finish_run();
  end

  initial begin
    // R8: outputs quiet in reset
    repeat (4) cyc();
    rst_n = 1'b1;
    // R7: disabled after reset
    repeat (4) cyc();

    // R2/R4/R6: exhaustive duty sweep without trim
    en = 1'b1;
    gtag = "R2 gate";
    for (int d = 0; d <= MAXV; d++) begin
      duty = CW'(d);
      repeat (2 * P) cyc();
    end

    // R5: trim offsets at both extremes, saturation included
    gtag = "R5 gate";
    for (int k = 0; k < 2; k++) begin
      ofs = (k == 0) ? -4'sd8 : 4'sd7;
      for (int d = 0; d <= MAXV; d++) begin
        duty = CW'(d);
        repeat (2 * P) cyc();
      end
    end

    // R3: inputs change within periods; only boundary values take effect
    gtag = "R3 gate";
    for (int n = 0; n < 20 * P; n++) begin
      cyc();
      lf_step();
      duty = lf[CW-1:0];
      if (n % 50 == 0) ofs = $signed(lf[OW+7:8]);
    end

    // R7: disable with inputs moving, then restart at a fresh period
    gtag = "R7 gate";
    en = 1'b0;
    ofs = '0;
    duty = CW'(20);
    repeat (3) cyc();
    duty = CW'(45);
    cyc();
    en = 1'b1;
    repeat (2 * P) cyc();
    repeat (40) cyc();
    en = 1'b0;
    cyc();
    en = 1'b1;
    repeat (2 * P) cyc();

    // R8: reset mid-run, enable held high
    rst_n = 1'b0;
    repeat (3) cyc();
    rst_n = 1'b1;
    duty = CW'(HALF + 1);
    repeat (2 * P + 1) cyc();

    finish_run();
  end
endmodule